// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a logical address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. It holds six segment registers. Each one keeps a hidden copy of its 8-byte descriptor. Software loads a selector into one register through a load stream. The block then reads the two descriptor words from the global or the local table over a single-outstanding memory read port, decodes them and stores the result. Every later translation through that register uses only the stored copy, so a translation costs no memory traffic.

A translation request names a register and an offset. One cycle after acceptance, the block returns either the linear address (base plus offset) or a fault code. The checks cover a null or unloaded register, a segment marked not present, privilege against the current level held in the code register, and the offset against a limit scaled by granularity.

The block has three valid/ready interfaces: selector loads (`ld_*`), memory requests (`mem_req_*`) and translation requests and results (`xl_*`, `rs_*`).
- A sender keeps valid and its payload steady until ready is seen at a clock edge.
- `rs_*` holds its result until `rs_ready` is high. While the result is held, no new request is accepted.
- A memory response arrives on `mem_rsp_valid` and has no ready signal. The block always takes it.
- The table base write port and the busy and level outputs are plain signals.

Top module: `seg_xlat`

## Requirements
- R1: A selector carries its table index in bits 15:3, the table choice in bit 2 (0 selects the global table, 1 the local table) and its requested level in bits 1:0. A load reads the low descriptor word at table base + index*8, then the high word at that address + 4.
- R2: The descriptor base is formed from high word bits 31:24, then high word bits 7:0, then low word bits 31:16 (most significant first). A translation with no fault returns this base + offset on `rs_lin`, modulo 2^32.
- R3: The 20-bit raw limit is formed from high word bits 19:16 above low word bits 15:0. High word bit 23 (granularity) equal to 0 makes the effective limit the raw limit. Bit 23 equal to 1 makes it {raw limit, 12'hFFF}. An offset equal to the effective limit passes. An offset above it gives fault code 01 (general protection).
- R4: A descriptor whose high word bit 15 (present) is 0 gives fault code 10 (not present) on translation.
- R5: The current level `cpl` is bits 1:0 of the selector last loaded into register 1 (the code register), and it is 0 after reset. A translation whose descriptor level (high word bits 14:13) is numerically below `cpl` gives fault code 11 (privilege).
- R6: A selector with index 0 and table bit 0 is null. Loading it issues no memory read and completes without setting a busy bit. Translating through a null register, a register never loaded since reset, or a register number of 6 or 7 gives fault code 01.
- R7: `seg_busy[n]` is high from the cycle after a load into register n is accepted until its descriptor is stored. At most one busy bit is set at a time. A translation request for a busy register is held off (`xl_ready` low), while requests for other registers are still accepted.
- R8: A result held with `rs_ready` low keeps `rs_valid`, `rs_lin` and `rs_fault` stable. A memory request not yet accepted keeps `mem_req_valid` and `mem_req_addr` stable. An accepted translation gives `rs_valid` on the next cycle.
- R9: When several faults apply, the order is null first, then not present, then privilege, then limit. Whenever `rs_fault` is non-zero, `rs_lin` is 0.
- R10: Table bases are written through `tbl_wr_en` (bit `tbl_wr_ldt` picks the local table). `ld_ready` is high after reset and low while a descriptor fetch is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Write a table base |
| tbl_wr_ldt | input | 1 | 0: global table base, 1: local table base |
| tbl_wr_base | input | 32 | Table base value |
| ld_valid | input | 1 | Selector load request |
| ld_ready | output | 1 | Load stream can accept |
| ld_seg | input | 3 | Target register number (0..5) |
| ld_sel | input | 16 | Selector to load |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data word |
| seg_busy | output | 6 | Per-register load in progress |
| cpl | output | 2 | Current privilege level |
| xl_valid | input | 1 | Translation request |
| xl_ready | output | 1 | Translation can be accepted |
| xl_seg | input | 3 | Register number for the translation |
| xl_off | input | 32 | Offset |
| rs_valid | output | 1 | Result available |
| rs_ready | input | 1 | Result consumer ready |
| rs_lin | output | 32 | Linear address (0 on fault) |
| rs_fault | output | 2 | 00 ok, 01 general protection, 10 not present, 11 privilege |

## Verification
The bench places descriptors in a memory model that drops `mem_req_ready` every third cycle. It checks the read order and the addresses from both tables, so a design that read the high word first or scaled the index wrongly would report wrong addresses or wrong bases. It probes offsets exactly at and one past each limit, in both granularities. An off-by-one compare, or a granularity fill on the wrong side of the limit, would show up there. Fault ordering is probed with descriptors that break two rules at once, so a design that checked the limit first would report the wrong code. It also checks that a load in progress stalls only its own register, that a null load reads no memory, and that a held result stays stable.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  localparam int unsigned AW    = 32;
  localparam int unsigned SEL_W = 16;
  localparam int unsigned LIM_W = 20;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_GP   = 2'b01,
    FLT_NP   = 2'b10,
    FLT_PRIV = 2'b11
  } flt_e;

  typedef enum logic [2:0] {
    LS_IDLE, LS_REQ_LO, LS_WAIT_LO, LS_REQ_HI, LS_WAIT_HI
  } ld_state_e;

  typedef struct packed {
    logic [AW-1:0] base;
    logic [AW-1:0] lim;
    logic [1:0]    dpl;
    logic [1:0]    rpl;
    logic          present;
    logic          is_null;
  } seg_ent_t;

  localparam seg_ent_t NULL_ENT = '{base: '0, lim: '0, dpl: 2'd0, rpl: 2'd0,
                                    present: 1'b0, is_null: 1'b1};

  function automatic logic sel_is_null(input logic [SEL_W-1:0] s);
    return (s[SEL_W-1:2] == '0);
  endfunction

  function automatic seg_ent_t desc_decode(input logic [1:0] rpl,
                                           input logic [31:0] lo,
                                           input logic [31:0] hi);
    seg_ent_t e;
    logic [LIM_W-1:0] raw;
    raw       = {hi[19:16], lo[15:0]};
    e.base    = {hi[31:24], hi[7:0], lo[31:16]};
    e.lim     = hi[23] ? {raw, 12'hFFF} : {12'h000, raw};
    e.dpl     = hi[14:13];
    e.rpl     = rpl;
    e.present = hi[15];
    e.is_null = 1'b0;
    return e;
  endfunction

endpackage

// File: rtl/seg_tbl_regs.sv
module seg_tbl_regs import seg_xlat_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_ldt,
  input  logic [AW-1:0] wr_base,
  output logic [AW-1:0] gdt_base,
  output logic [AW-1:0] ldt_base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gdt_base <= '0;
      ldt_base <= '0;
    end else if (wr_en) begin
      if (wr_ldt) ldt_base <= wr_base;
      else        gdt_base <= wr_base;
    end
  end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader import seg_xlat_pkg::*; #(
  parameter  int NSEG  = 6,
  localparam int SEG_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [SEG_W-1:0] ld_seg,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [AW-1:0]    gdt_base,
  input  logic [AW-1:0]    ldt_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             wr_en,
  output logic [SEG_W-1:0] wr_idx,
  output seg_ent_t         wr_ent,
  output logic [NSEG-1:0]  busy
);
  ld_state_e        st;
  logic [AW-1:0]    addr_q;
  logic [SEG_W-1:0] seg_q;
  logic [1:0]       rpl_q;
  logic [31:0]      lo_q;
  logic             seg_ok, sel_null;
  logic [AW-1:0]    tbl_base, desc_addr;

  assign seg_ok    = (int'(ld_seg) < NSEG);
  assign sel_null  = sel_is_null(ld_sel);
  assign tbl_base  = ld_sel[2] ? ldt_base : gdt_base;
  assign desc_addr = tbl_base + {16'b0, ld_sel[SEL_W-1:3], 3'b000};

  assign ld_ready      = (st == LS_IDLE);
  assign mem_req_valid = (st == LS_REQ_LO) || (st == LS_REQ_HI);
  assign mem_req_addr  = (st == LS_REQ_HI) ? addr_q + 32'd4 : addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= LS_IDLE;
      addr_q <= '0;
      seg_q  <= '0;
      rpl_q  <= '0;
      lo_q   <= '0;
    end else begin
      case (st)
        LS_IDLE: if (ld_valid && seg_ok && !sel_null) begin
          st     <= LS_REQ_LO;
          addr_q <= desc_addr;
          seg_q  <= ld_seg;
          rpl_q  <= ld_sel[1:0];
        end
        LS_REQ_LO:  if (mem_req_ready) st <= LS_WAIT_LO;
        LS_WAIT_LO: if (mem_rsp_valid) begin
          lo_q <= mem_rsp_data;
          st   <= LS_REQ_HI;
        end
        LS_REQ_HI:  if (mem_req_ready) st <= LS_WAIT_HI;
        LS_WAIT_HI: if (mem_rsp_valid) st <= LS_IDLE;
        default:    st <= LS_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = seg_q;
    wr_ent = desc_decode(rpl_q, lo_q, mem_rsp_data);
    if (st == LS_IDLE && ld_valid && seg_ok && sel_null) begin
      wr_en      = 1'b1;
      wr_idx     = ld_seg;
      wr_ent     = NULL_ENT;
      wr_ent.rpl = ld_sel[1:0];
    end else if (st == LS_WAIT_HI && mem_rsp_valid) begin
      wr_en = 1'b1;
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_busy
    assign busy[i] = (st != LS_IDLE) && (seg_q == SEG_W'(i));
  end
endmodule

// File: rtl/seg_cache.sv
module seg_cache import seg_xlat_pkg::*; #(
  parameter  int NSEG     = 6,
  parameter  int CODE_SEG = 1,
  localparam int SEG_W    = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  seg_ent_t         wr_ent,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [AW-1:0]    rd_base,
  output logic [AW-1:0]    rd_lim,
  output logic [1:0]       rd_dpl,
  output logic             rd_present,
  output logic             rd_null,
  output logic [1:0]       cpl
);
  logic [AW-1:0] base_q [NSEG];
  logic [AW-1:0] lim_q  [NSEG];
  logic [1:0]    dpl_q  [NSEG];
  logic          pres_q [NSEG];
  logic          null_q [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        dpl_q[i]  <= '0;
        pres_q[i] <= 1'b0;
        null_q[i] <= 1'b1;
      end else if (wr_en && wr_idx == SEG_W'(i)) begin
        base_q[i] <= wr_ent.base;
        lim_q[i]  <= wr_ent.lim;
        dpl_q[i]  <= wr_ent.dpl;
        pres_q[i] <= wr_ent.present;
        null_q[i] <= wr_ent.is_null;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cpl <= 2'd0;
    else if (wr_en && wr_idx == SEG_W'(CODE_SEG)) cpl <= wr_ent.rpl;
  end

  always_comb begin
    rd_base    = '0;
    rd_lim     = '0;
    rd_dpl     = '0;
    rd_present = 1'b0;
    rd_null    = 1'b1;
    for (int i = 0; i < NSEG; i++) begin
      if (rd_idx == SEG_W'(i)) begin
        rd_base    = base_q[i];
        rd_lim     = lim_q[i];
        rd_dpl     = dpl_q[i];
        rd_present = pres_q[i];
        rd_null    = null_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_xlat_core.sv
module seg_xlat_core import seg_xlat_pkg::*; #(
  parameter  int NSEG  = 6,
  localparam int SEG_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xl_valid,
  output logic             xl_ready,
  input  logic [SEG_W-1:0] xl_seg,
  input  logic [AW-1:0]    xl_off,
  input  logic [NSEG-1:0]  busy,
  input  logic [AW-1:0]    ent_base,
  input  logic [AW-1:0]    ent_lim,
  input  logic [1:0]       ent_dpl,
  input  logic             ent_present,
  input  logic             ent_null,
  input  logic [1:0]       cpl,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic [AW-1:0]    rs_lin,
  output logic [1:0]       rs_fault
);
  logic   seg_stall, out_free;
  flt_e   flt;
  logic [AW-1:0] lin;

  always_comb begin
    seg_stall = 1'b0;
    for (int i = 0; i < NSEG; i++)
      if (xl_seg == SEG_W'(i) && busy[i]) seg_stall = 1'b1;
  end

  assign out_free = !rs_valid || rs_ready;
  assign xl_ready = out_free && !seg_stall;

  always_comb begin
    if (ent_null)              flt = FLT_GP;
    else if (!ent_present)     flt = FLT_NP;
    else if (cpl > ent_dpl)    flt = FLT_PRIV;
    else if (xl_off > ent_lim) flt = FLT_GP;
    else                       flt = FLT_NONE;
    lin = (flt == FLT_NONE) ? ent_base + xl_off : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_lin   <= '0;
      rs_fault <= FLT_NONE;
    end else if (xl_valid && xl_ready) begin
      rs_valid <= 1'b1;
      rs_lin   <= lin;
      rs_fault <= flt;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat import seg_xlat_pkg::*; #(
  parameter  int NSEG     = 6,
  parameter  int CODE_SEG = 1,
  localparam int SEG_W    = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_wr_en,
  input  logic             tbl_wr_ldt,
  input  logic [31:0]      tbl_wr_base,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [SEG_W-1:0] ld_seg,
  input  logic [15:0]      ld_sel,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [31:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic [NSEG-1:0]  seg_busy,
  output logic [1:0]       cpl,
  input  logic             xl_valid,
  output logic             xl_ready,
  input  logic [SEG_W-1:0] xl_seg,
  input  logic [31:0]      xl_off,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic [31:0]      rs_lin,
  output logic [1:0]       rs_fault
);
  logic [AW-1:0]    gdt_base, ldt_base;
  logic             wr_en;
  logic [SEG_W-1:0] wr_idx;
  seg_ent_t         wr_ent;
  logic [AW-1:0]    ent_base, ent_lim;
  logic [1:0]       ent_dpl;
  logic             ent_present, ent_null;

  seg_tbl_regs u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_ldt(tbl_wr_ldt),
    .wr_base(tbl_wr_base), .gdt_base(gdt_base), .ldt_base(ldt_base)
  );

  seg_desc_loader #(.NSEG(NSEG)) u_ld (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_seg(ld_seg), .ld_sel(ld_sel), .gdt_base(gdt_base), .ldt_base(ldt_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .busy(seg_busy)
  );

  seg_cache #(.NSEG(NSEG), .CODE_SEG(CODE_SEG)) u_cache (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .rd_idx(xl_seg), .rd_base(ent_base), .rd_lim(ent_lim), .rd_dpl(ent_dpl),
    .rd_present(ent_present), .rd_null(ent_null), .cpl(cpl)
  );

  seg_xlat_core #(.NSEG(NSEG)) u_core (
    .clk(clk), .rst_n(rst_n), .xl_valid(xl_valid), .xl_ready(xl_ready),
    .xl_seg(xl_seg), .xl_off(xl_off), .busy(seg_busy), .ent_base(ent_base),
    .ent_lim(ent_lim), .ent_dpl(ent_dpl), .ent_present(ent_present),
    .ent_null(ent_null), .cpl(cpl), .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_lin(rs_lin), .rs_fault(rs_fault)
  );
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter  int NSEG  = 6,
  localparam int SEG_W = $clog2(NSEG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [31:0]      mem_req_addr,
  input logic [NSEG-1:0]  seg_busy,
  input logic             xl_valid,
  input logic             xl_ready,
  input logic [SEG_W-1:0] xl_seg,
  input logic             rs_valid,
  input logic             rs_ready,
  input logic [31:0]      rs_lin,
  input logic [1:0]       rs_fault
);
  logic tgt_busy;
  always_comb begin
    tgt_busy = 1'b0;
    for (int i = 0; i < NSEG; i++)
      if (xl_seg == SEG_W'(i) && seg_busy[i]) tgt_busy = 1'b1;
  end

  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && tgt_busy |-> !xl_ready);  // R7
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seg_busy));  // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));  // R8
  AST_RS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_lin) && $stable(rs_fault));  // R8
  AST_RS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && xl_ready |=> rs_valid);  // R8
  AST_FAULT_ZERO_LIN: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && (rs_fault != 2'b00) |-> rs_lin == 32'd0);  // R9
  AST_FETCH_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !ld_ready);  // R10
endmodule

bind seg_xlat seg_xlat_chk #(.NSEG(NSEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .seg_busy(seg_busy), .xl_valid(xl_valid), .xl_ready(xl_ready),
  .xl_seg(xl_seg), .rs_valid(rs_valid), .rs_ready(rs_ready),
  .rs_lin(rs_lin), .rs_fault(rs_fault)
);

// File: tb/seg_xlat_test.sv
`timescale 1ns/1ps
module seg_xlat_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tbl_wr_en = 0, tbl_wr_ldt = 0;
  logic [31:0] tbl_wr_base = 0;
  logic        ld_valid = 0;
  logic        ld_ready;
  logic [2:0]  ld_seg = 0;
  logic [15:0] ld_sel = 0;
  logic        mem_req_valid, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic [5:0]  seg_busy;
  logic [1:0]  cpl;
  logic        xl_valid = 0, xl_ready;
  logic [2:0]  xl_seg = 0;
  logic [31:0] xl_off = 0;
  logic        rs_valid, rs_ready = 1;
  logic [31:0] rs_lin;
  logic [1:0]  rs_fault;

  always #10 clk = ~clk;

  seg_xlat uut (.*);

  int checks = 0, fails = 0;
  logic [31:0] mem [0:127];
  logic [31:0] rd_log [0:63];
  int          rd_count = 0;
  logic        hs = 0;
  logic [31:0] hs_addr = 0;
  int          cyc = 0;
  logic        hold_rs = 0;
  logic [31:0] exp_lin_q [$];
  logic [1:0]  exp_flt_q [$];
  string       exp_tag_q [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_lo(input logic [31:0] b, input logic [19:0] l);
    return {b[15:0], l[15:0]};
  endfunction
  function automatic logic [31:0] mk_hi(input logic [31:0] b, input logic [19:0] l,
                                        input logic g, input logic p, input logic [1:0] d);
    return {b[31:24], g, 1'b1, 2'b00, l[19:16], p, d, 1'b1, 4'h2, b[23:16]};
  endfunction

  // memory model: handshake log at the edge, response on the following cycle
  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      rd_log[rd_count[5:0]] <= mem_req_addr;
      rd_count <= rd_count + 1;
      hs <= 1'b1;
      hs_addr <= mem_req_addr;
    end else hs <= 1'b0;
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    mem_rsp_valid = hs;
    mem_rsp_data  = mem[hs_addr[8:2]];
    mem_req_ready = (cyc % 3) != 1;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    rs_ready = !hold_rs;
    #1;
    if (rs_valid && rs_ready) begin
      if (exp_lin_q.size() == 0) chk("R8 unexpected result", 32'd1, 32'd0);
      else begin
        string t;
        logic [31:0] el;
        logic [1:0]  ef;
        t  = exp_tag_q.pop_front();
        el = exp_lin_q.pop_front();
        ef = exp_flt_q.pop_front();
        chk({t, " fault"}, {30'd0, rs_fault}, {30'd0, ef});
        chk({t, " lin"}, rs_lin, el);
      end
    end
  end

  task automatic xlate(input int seg, input logic [31:0] off, input logic [31:0] elin,
                       input logic [1:0] eflt, input string tag);
    exp_lin_q.push_back(elin);
    exp_flt_q.push_back(eflt);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    xl_valid = 1; xl_seg = 3'(seg); xl_off = off;
    #2;
    while (!xl_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    xl_valid = 0;
  endtask

  task automatic do_load(input int seg, input logic [15:0] sel);
    @(negedge clk);
    ld_valid = 1; ld_seg = 3'(seg); ld_sel = sel;
    #2;
    while (!ld_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    ld_valid = 0;
    @(negedge clk);
    while (seg_busy != 0) @(negedge clk);
  endtask

  task automatic wr_tbl(input logic ldt, input logic [31:0] b);
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_ldt = ldt; tbl_wr_base = b;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic drain;
    int n = 0;
    while (exp_lin_q.size() != 0 && n < 50) begin @(negedge clk); n++; end
  endtask

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'd0;
    // global table at 0x40: index n -> word 16+2n
    mem[18] = mk_lo(32'h1000_0000, 20'h00FFF); mem[19] = mk_hi(32'h1000_0000, 20'h00FFF, 0, 1, 2'd0);
    mem[20] = mk_lo(32'h0012_3400, 20'h00010); mem[21] = mk_hi(32'h0012_3400, 20'h00010, 1, 1, 2'd3);
    mem[22] = mk_lo(32'h0,         20'hFFFFF); mem[23] = mk_hi(32'h0,         20'hFFFFF, 1, 1, 2'd3);
    mem[24] = mk_lo(32'h0,         20'h00000); mem[25] = mk_hi(32'h0,         20'h00000, 0, 0, 2'd3);
    mem[26] = mk_lo(32'h0000_5000, 20'h0FFFF); mem[27] = mk_hi(32'h0000_5000, 20'h0FFFF, 0, 1, 2'd0);
    // local table at 0x100: index 1 -> word 66
    mem[66] = mk_lo(32'hABCD_0000, 20'h000FF); mem[67] = mk_hi(32'hABCD_0000, 20'h000FF, 0, 1, 2'd3);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset ld_ready", {31'd0, ld_ready}, 32'd1);
    chk("R7 reset busy", {26'd0, seg_busy}, 32'd0);
    chk("R8 reset rs_valid", {31'd0, rs_valid}, 32'd0);
    chk("R5 reset cpl", {30'd0, cpl}, 32'd0);
    chk("R10 reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

    wr_tbl(1'b0, 32'h40);
    wr_tbl(1'b1, 32'h100);

    xlate(0, 32'h10, 32'd0, 2'b01, "R6 unloaded register");
    xlate(6, 32'h10, 32'd0, 2'b01, "R6 register number 6");

    do_load(1, 16'h0008);
    chk("R1 gdt low addr", rd_log[0], 32'h48);
    chk("R1 gdt high addr", rd_log[1], 32'h4C);
    chk("R5 cpl from code load", {30'd0, cpl}, 32'd0);
    xlate(1, 32'hFFF, 32'h1000_0FFF, 2'b00, "R3 byte limit equal");
    xlate(1, 32'h1000, 32'd0, 2'b01, "R3 byte limit plus one");

    do_load(3, 16'h0013);
    xlate(3, 32'h10FFF, 32'h0013_43FF, 2'b00, "R3 page limit equal");
    xlate(3, 32'h11000, 32'd0, 2'b01, "R3 page limit plus one");

    do_load(0, 16'h000C);
    chk("R1 ldt low addr", rd_log[4], 32'h108);
    chk("R1 ldt high addr", rd_log[5], 32'h10C);
    xlate(0, 32'h80, 32'hABCD_0080, 2'b00, "R2 split base");
    xlate(0, 32'h100, 32'd0, 2'b01, "R3 ldt limit plus one");

    do_load(4, 16'h0020);
    xlate(4, 32'h0, 32'd0, 2'b10, "R4 not present");
    xlate(4, 32'h100, 32'd0, 2'b10, "R9 not present before limit");

    do_load(5, 16'h0028);
    xlate(5, 32'h10, 32'h0000_5010, 2'b00, "R5 level 0 at cpl 0");

    do_load(1, 16'h001B);
    chk("R5 cpl after reload", {30'd0, cpl}, 32'd3);
    xlate(5, 32'h10, 32'd0, 2'b11, "R5 level 0 at cpl 3");
    xlate(5, 32'h20000, 32'd0, 2'b11, "R9 privilege before limit");
    xlate(3, 32'h0, 32'h0012_3400, 2'b00, "R5 level 3 at cpl 3");
    xlate(1, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 2'b00, "R2 flat code segment");
    drain();

    // R7 / R10: load in progress stalls only its own register
    @(negedge clk);
    ld_valid = 1; ld_seg = 3'd3; ld_sel = 16'h0013;
    @(posedge clk); #1;
    ld_valid = 0;
    @(negedge clk); #2;
    chk("R7 busy bit set", {26'd0, seg_busy}, 32'h08);
    chk("R10 ld_ready low in fetch", {31'd0, ld_ready}, 32'd0);
    xl_valid = 1; xl_seg = 3'd3; xl_off = 0; #1;
    chk("R7 busy register stalls", {31'd0, xl_ready}, 32'd0);
    xl_seg = 3'd0; #1;
    chk("R7 other register proceeds", {31'd0, xl_ready}, 32'd1);
    xl_valid = 0;
    while (seg_busy != 0) @(negedge clk);
    xlate(3, 32'h4, 32'h0012_3404, 2'b00, "R7 after reload");
    drain();

    // R8: held result stays stable
    hold_rs = 1;
    xlate(3, 32'h8, 32'h0012_3408, 2'b00, "R8 released result");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      chk("R8 held valid", {31'd0, rs_valid}, 32'd1);
      chk("R8 held lin", rs_lin, 32'h0012_3408);
    end
    hold_rs = 0;
    drain();

    // R6: null load reads nothing and faults
    begin
      int rc;
      rc = rd_count;
      do_load(3, 16'h0003);
      chk("R6 null load reads", rd_count, rc);
    end
    xlate(3, 32'h0, 32'd0, 2'b01, "R6 null register");
    drain();
    chk("R8 scoreboard empty", exp_lin_q.size(), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule